// File: doc/BRIEF.md
# Memory Protection Region Register Bank

This block holds the configuration of a small memory protection unit and checks accesses against it. Software programs the block through a 32-bit register port. The port reaches a control word, a region selector and two attribute words. It also reaches a set of windows, each a pair of words, that load one region's lower bound and upper bound. The first window always targets the selected region. The other windows target the neighbours in the selector's aligned group, so several regions can be loaded in a row without rewriting the selector.

Each region starts on a 32-byte boundary and ends at the last byte of the 32-byte granule named by its upper bound. A purely combinational lookup port takes an address and the kind of access: read or write, privileged or not, data or instruction fetch. It returns the winning region, that region's permission and no-execute bits, and the 8-bit memory attribute the region indexes. It also raises a fault when the access is not allowed.

Top module: `mpu_region_bank`

## Requirements
- R1: After reset every readable register reads 0, every region is disabled and the unit is off.
- R2: The selector register sits at offset 0x08. It keeps the low 3 bits of a write, reads back zero-extended, and ignores the upper bits.
- R3: The lower-bound word of a window holds, from the top down, the base in [31:5], shareability in [4:3], access permission in [2:1] and no-execute in [0]. Shareability takes the values 0 (not shared), 2 (outer) and 3 (inner). It reads back exactly as written.
- R4: The upper-bound word holds the limit in [31:5], the attribute index in [3:1] and the region enable in [0]. Bit 4 always reads 0. Writing 0 disables the region.
- R5: The primary window at offsets 0x0C/0x10 targets the selected region. Window k (k = 1..3), at offsets 0x0C+8k and 0x10+8k, targets region (selector with its two low bits cleared) + k.
- R6: Attribute word 0x30 holds indices 0 to 3 and word 0x34 holds indices 4 to 7. Index i sits in byte i mod 4. The lookup returns the byte indexed by the hit region.
- R7: An enabled region matches an address from its base up to its limit with the low 5 bits taken as all ones. When regions overlap, the lowest-numbered region wins. When nothing matches, region, permission, no-execute and attribute all read 0.
- R8: On a match, a fault is raised when a write meets permission bit 1 set (read-only), when an unprivileged access meets permission bit 0 clear (privileged only), or when a fetch meets no-execute set.
- R9: Control register 0x04 has the unit enable in bit 0 and the default-map enable in bit 2. Its other bits read 0. With the unit off, every lookup shows no hit and no fault.
- R10: With the unit on and no region matching, a privileged access faults unless the default map is enabled, and an unprivileged access always faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| lkAddr | input | 32 | Lookup address |
| lkWrite | input | 1 | Access is a write |
| lkPriv | input | 1 | Access is privileged |
| lkFetch | input | 1 | Access is an instruction fetch |
| lkHit | output | 1 | An enabled region matched |
| lkRegion | output | 3 | Winning region number |
| lkPerm | output | 2 | Access permission bits of the winning region |
| lkXn | output | 1 | No-execute bit of the winning region |
| lkAttr | output | 8 | Selected memory attribute byte |
| lkFault | output | 1 | Access is denied |

## Verification
Most internal errors show up at the ports in the cycle after the register write that causes them. A window that decodes to the wrong region is visible at once when the selector is changed and the primary window is read back. A wrong priority or bound comparison shows as the wrong region number or attribute on the very next lookup, because the lookup path holds no state. Overlapping regions, the exact first and last byte of a granule, and a region disabled by a zero write are all probed so that an off-by-one or a stale enable changes a visible field.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  parameter int NUM_REGIONS = 8;
  parameter int NUM_ALIASES = 4;
  parameter int ADDR_W      = 8;
  parameter int DATA_W      = 32;
  localparam int REG_W      = $clog2(NUM_REGIONS);
  localparam int WIN_W      = $clog2(NUM_ALIASES);
  localparam int GRAN_LSB   = 5;
  localparam int HI_W       = DATA_W - GRAN_LSB;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_NUM   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_WIN   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_ATTR0 = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_ATTR1 = 8'h34;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_NUM, RD_BASE, RD_LIMIT, RD_ATTR0, RD_ATTR1
  } rdSel_t;

  typedef struct packed {
    logic             wrCtrl;
    logic             wrNum;
    logic             wrBase;
    logic             wrLimit;
    logic [1:0]       wrAttr;
    logic [WIN_W-1:0] winIdx;
    rdSel_t           rdSel;
  } regStrobe_t;

  typedef struct packed {
    logic [HI_W-1:0] baseHi;
    logic [1:0]      sh;
    logic [1:0]      ap;
    logic            xn;
    logic [HI_W-1:0] limHi;
    logic [2:0]      attrIdx;
    logic            en;
  } region_t;
endpackage

// File: rtl/mpu_reg_ctrl.sv
module mpu_reg_ctrl
  import mpu_pkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] WIN_HI = OFF_WIN + ADDR_W'(8 * NUM_ALIASES);

  logic [ADDR_W-1:0] offs;
  logic inWin;
  logic isLim;

  always_comb begin
    offs  = regAddr - OFF_WIN;
    isLim = offs[2];
    inWin = (offs[1:0] == 2'b00) && (regAddr >= OFF_WIN) && (regAddr < WIN_HI);
    strobe = '0;
    strobe.winIdx = WIN_W'(offs >> 3);
    strobe.rdSel  = RD_NONE;
    if (inWin) begin
      strobe.rdSel   = isLim ? RD_LIMIT : RD_BASE;
      strobe.wrBase  = regWe && !isLim;
      strobe.wrLimit = regWe && isLim;
    end else begin
      case (regAddr)
        OFF_CTRL:  begin strobe.rdSel = RD_CTRL;  strobe.wrCtrl    = regWe; end
        OFF_NUM:   begin strobe.rdSel = RD_NUM;   strobe.wrNum     = regWe; end
        OFF_ATTR0: begin strobe.rdSel = RD_ATTR0; strobe.wrAttr[0] = regWe; end
        OFF_ATTR1: begin strobe.rdSel = RD_ATTR1; strobe.wrAttr[1] = regWe; end
        default:   strobe.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mpu_datapath.sv
module mpu_datapath
  import mpu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] lkAddr,
  input  logic              lkWrite,
  input  logic              lkPriv,
  input  logic              lkFetch,
  output logic              lkHit,
  output logic [REG_W-1:0]  lkRegion,
  output logic [1:0]        lkPerm,
  output logic              lkXn,
  output logic [7:0]        lkAttr,
  output logic              lkFault
);
  localparam logic [REG_W-1:0] GRP_MASK = REG_W'(NUM_ALIASES - 1);

  region_t                  regions [NUM_REGIONS];
  logic                     ctrlEn;
  logic                     ctrlDef;
  logic [REG_W-1:0]         numQ;
  logic [1:0][DATA_W-1:0]   attrQ;
  logic [REG_W-1:0]         tgt;
  logic [NUM_REGIONS-1:0]   hitVec;
  logic [REG_W-1:0]         selIdx;
  region_t                  selReg;

  // window target: primary follows the selector, others index within its group
  always_comb begin
    if (strobe.winIdx == '0) tgt = numQ;
    else                     tgt = (numQ & ~GRP_MASK) + REG_W'(strobe.winIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      ctrlDef <= 1'b0;
      numQ    <= '0;
      attrQ   <= '0;
    end else begin
      if (strobe.wrCtrl) begin
        ctrlEn  <= regWdata[0];
        ctrlDef <= regWdata[2];
      end
      if (strobe.wrNum) numQ <= regWdata[REG_W-1:0];
      if (strobe.wrAttr[0]) attrQ[0] <= regWdata;
      if (strobe.wrAttr[1]) attrQ[1] <= regWdata;
    end
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regions[i] <= '0;
      end else if (tgt == REG_W'(i)) begin
        if (strobe.wrBase) begin
          regions[i].baseHi <= regWdata[DATA_W-1:GRAN_LSB];
          regions[i].sh     <= regWdata[4:3];
          regions[i].ap     <= regWdata[2:1];
          regions[i].xn     <= regWdata[0];
        end
        if (strobe.wrLimit) begin
          regions[i].limHi   <= regWdata[DATA_W-1:GRAN_LSB];
          regions[i].attrIdx <= regWdata[3:1];
          regions[i].en      <= regWdata[0];
        end
      end
    end
    assign hitVec[i] = regions[i].en &&
                       (lkAddr[DATA_W-1:GRAN_LSB] >= regions[i].baseHi) &&
                       (lkAddr[DATA_W-1:GRAN_LSB] <= regions[i].limHi);
  end

  always_comb begin
    regRdata = '0;
    case (strobe.rdSel)
      RD_CTRL:  regRdata = {{(DATA_W-3){1'b0}}, ctrlDef, 1'b0, ctrlEn};
      RD_NUM:   regRdata = DATA_W'(numQ);
      RD_BASE:  regRdata = {regions[tgt].baseHi, regions[tgt].sh, regions[tgt].ap, regions[tgt].xn};
      RD_LIMIT: regRdata = {regions[tgt].limHi, 1'b0, regions[tgt].attrIdx, regions[tgt].en};
      RD_ATTR0: regRdata = attrQ[0];
      RD_ATTR1: regRdata = attrQ[1];
      default:  regRdata = '0;
    endcase
  end

  // lowest-numbered matching region wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = REG_W'(i);
    end
    selReg = regions[selIdx];
  end

  always_comb begin
    lkHit    = ctrlEn && (hitVec != '0);
    lkRegion = lkHit ? selIdx : '0;
    lkPerm   = lkHit ? selReg.ap : 2'b00;
    lkXn     = lkHit && selReg.xn;
    lkAttr   = lkHit ? attrQ[selReg.attrIdx[2]][8*selReg.attrIdx[1:0] +: 8] : 8'h00;
    if (!ctrlEn)    lkFault = 1'b0;
    else if (lkHit) lkFault = (lkWrite && selReg.ap[1]) || (!lkPriv && !selReg.ap[0]) ||
                              (lkFetch && selReg.xn);
    else            lkFault = !lkPriv || !ctrlDef;
  end

  assert_num_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrNum |=> numQ == $past(regWdata[REG_W-1:0]));

  assert_zero_disables_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrLimit && regWdata == '0) |=> !regions[$past(tgt)].en);

  assert_hit_in_bounds_R7: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkAddr[DATA_W-1:GRAN_LSB] >= regions[lkRegion].baseHi &&
               lkAddr[DATA_W-1:GRAN_LSB] <= regions[lkRegion].limHi &&
               regions[lkRegion].en));

  assert_fault_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && lkFault) |-> ((lkWrite && lkPerm[1]) || (!lkPriv && !lkPerm[0]) ||
                            (lkFetch && lkXn)));

  assert_off_passes_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |-> (!lkFault && !lkHit));

  assert_unpriv_miss_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEn && !lkHit && !lkPriv) |-> lkFault);
endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] lkAddr,
  input  logic              lkWrite,
  input  logic              lkPriv,
  input  logic              lkFetch,
  output logic              lkHit,
  output logic [REG_W-1:0]  lkRegion,
  output logic [1:0]        lkPerm,
  output logic              lkXn,
  output logic [7:0]        lkAttr,
  output logic              lkFault
);
  regStrobe_t strobe;

  mpu_reg_ctrl i_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  mpu_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .lkAddr   (lkAddr),
    .lkWrite  (lkWrite),
    .lkPriv   (lkPriv),
    .lkFetch  (lkFetch),
    .lkHit    (lkHit),
    .lkRegion (lkRegion),
    .lkPerm   (lkPerm),
    .lkXn     (lkXn),
    .lkAttr   (lkAttr),
    .lkFault  (lkFault)
  );
endmodule

// File: tb/test_mpu_region_bank.sv
module test_mpu_region_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] lkAddr = '0;
  logic        lkWrite = 1'b0, lkPriv = 1'b1, lkFetch = 1'b0;
  logic        lkHit, lkXn, lkFault;
  logic [2:0]  lkRegion;
  logic [1:0]  lkPerm;
  logic [7:0]  lkAttr;

  // 4 time units per period: 250 MHz with 1 ns units
  always #2 clk = ~clk;

  mpu_region_bank i_mpu_region_bank (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .lkAddr(lkAddr), .lkWrite(lkWrite), .lkPriv(lkPriv),
    .lkFetch(lkFetch), .lkHit(lkHit), .lkRegion(lkRegion), .lkPerm(lkPerm),
    .lkXn(lkXn), .lkAttr(lkAttr), .lkFault(lkFault)
  );

  typedef struct {
    bit          isLook;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [31:0] lookVec(logic h, logic [2:0] r, logic [1:0] p,
                                          logic x, logic [7:0] a, logic f);
    return {16'h0, h, r, p, x, a, f};
  endfunction

  // monitor: pops the expected item and compares it on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.isLook ? lookVec(lkHit, lkRegion, lkPerm, lkXn, lkAttr, lkFault) : regRdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    regAddr = a;
    it.isLook = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic look(input logic [31:0] a, input logic w, input logic p, input logic f,
                      input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    lkAddr = a; lkWrite = w; lkPriv = p; lkFetch = f;
    it.isLook = 1'b1; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    rd(8'h04, 32'h0, "R1 ctrl");
    rd(8'h08, 32'h0, "R1 num");
    rd(8'h0C, 32'h0, "R1 base");
    rd(8'h10, 32'h0, "R1 limit");
    rd(8'h34, 32'h0, "R1 attr1");
    look(32'h1010, 1'b1, 1'b0, 1'b0, lookVec(0, 0, 0, 0, 8'h00, 0), "R1 off lookup");

    // R2: selector keeps low bits only
    wr(8'h08, 32'hFFFF_FFFD);
    rd(8'h08, 32'h5, "R2 num");

    // R9: control keeps bits 0 and 2
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h5, "R9 ctrl readback");
    wr(8'h04, 32'h0);

    // R5: windows target the selector's group
    wr(8'h08, 32'h6);
    wr(8'h14, 32'h0000_2005);  // window 1 -> region 5
    wr(8'h18, 32'h0000_20EB);
    wr(8'h08, 32'h5);
    wr(8'h1C, 32'h0000_3000);  // window 2 -> region 6
    rd(8'h0C, 32'h0000_2005, "R5 primary sees region5");
    rd(8'h14, 32'h0000_2005, "R5 window1 sees region5");
    wr(8'h08, 32'h6);
    rd(8'h0C, 32'h0000_3000, "R5 window2 wrote region6");

    // R3 R4: region 1 via primary window
    wr(8'h08, 32'h1);
    wr(8'h0C, 32'h0000_101A);
    wr(8'h10, 32'h0000_10F5);
    rd(8'h0C, 32'h0000_101A, "R3 base readback");
    rd(8'h10, 32'h0000_10E5, "R4 limit readback bit4 zero");

    // region 0 overlaps the start of region 1
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h0000_1001);
    wr(8'h10, 32'h0000_1001);

    // R6: attribute bytes
    wr(8'h30, 32'h4433_2211);
    wr(8'h34, 32'h8877_6655);
    rd(8'h34, 32'h8877_6655, "R6 attr1 readback");

    wr(8'h04, 32'h5);
    look(32'h1010, 0, 1, 0, lookVec(1, 0, 2'b00, 1, 8'h11, 0), "R7 overlap lowest wins");
    look(32'h1010, 0, 0, 0, lookVec(1, 0, 2'b00, 1, 8'h11, 1), "R8 unpriv on priv-only");
    look(32'h1040, 0, 0, 0, lookVec(1, 1, 2'b01, 0, 8'h33, 0), "R6 R7 region1 attr idx2");
    look(32'h10FF, 1, 1, 0, lookVec(1, 1, 2'b01, 0, 8'h33, 0), "R7 last byte of granule");
    look(32'h0FFF, 0, 1, 0, lookVec(0, 0, 2'b00, 0, 8'h00, 0), "R10 below base default map");
    look(32'h1100, 0, 1, 0, lookVec(0, 0, 2'b00, 0, 8'h00, 0), "R10 priv miss default map");
    look(32'h1100, 0, 0, 0, lookVec(0, 0, 2'b00, 0, 8'h00, 1), "R10 unpriv miss");
    look(32'h2000, 1, 1, 0, lookVec(1, 5, 2'b10, 1, 8'h66, 1), "R8 write read-only");
    look(32'h2010, 0, 1, 1, lookVec(1, 5, 2'b10, 1, 8'h66, 1), "R8 fetch no-execute");
    look(32'h2010, 0, 1, 0, lookVec(1, 5, 2'b10, 1, 8'h66, 0), "R8 priv read ok");
    look(32'h1020, 0, 1, 1, lookVec(1, 1, 2'b01, 0, 8'h33, 0), "R8 fetch allowed");
    look(32'h3000, 0, 1, 0, lookVec(0, 0, 2'b00, 0, 8'h00, 0), "R4 never enabled");

    wr(8'h04, 32'h1);
    look(32'h1100, 0, 1, 0, lookVec(0, 0, 2'b00, 0, 8'h00, 1), "R10 priv miss no default");

    wr(8'h08, 32'h0);
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h0, "R4 zero limit readback");
    look(32'h1010, 0, 1, 0, lookVec(1, 1, 2'b01, 0, 8'h33, 0), "R4 region0 disabled");

    wr(8'h04, 32'h0);
    look(32'h2000, 1, 1, 0, lookVec(0, 0, 2'b00, 0, 8'h00, 0), "R9 off passes");

    @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule